// File: doc/BRIEF.md
# Fixed-Page Stack Pointer with Stack Memory

This block provides the stack pointer and stack storage for a small 8-bit processor core. It keeps a 16-bit stack address whose upper part is wired to a fixed value. Only the low six bits can change, so every stack access falls inside the 64-byte page from 0x00C0 to 0x00FF. The block also holds the 64-byte stack memory, indexed by those six low bits.

The core drives one request per cycle: a push with a data byte, a pull, or a command that reloads the pointer to the top of the page. A push stores its byte at the current address and then moves the pointer down. A pull moves the pointer up and then reads the byte at the new address. The pulled byte appears on a registered output one cycle later.

At either end of the page the pointer wraps silently, with no flag. If a push and a pull arrive in the same cycle, the block rejects both. It then raises a one-cycle error pulse.

Top module: `stack_window_sp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sp_addr` is 0x00FF, `pop_data` is 0x00 and `clash_err` is 0.
- R2: A push alone (`push_req`=1, `pull_req`=0, `rsp_cmd`=0) writes `push_data` into the stack memory at the current `sp_addr`. At the next clock edge `sp_addr` decreases by one.
- R3: A pull alone increases `sp_addr` by one at the clock edge. In the cycle after the request, `pop_data` holds the byte stored at the new address.
- R4: `rsp_cmd`=1 sets `sp_addr` to 0x00FF at the next edge. It takes priority over `push_req` and `pull_req`, which are then ignored: no write, no read, and no error pulse.
- R5: `sp_addr[15:8]` is always 0x00 and `sp_addr[7:6]` is always 2'b11.
- R6: A push at 0x00C0 writes entry 0 and moves the pointer to 0x00FF, with no flag.
- R7: A pull at 0x00FF moves the pointer to 0x00C0 and returns the byte in entry 0, with no flag.
- R8: A push and a pull together with `rsp_cmd`=0 leave `sp_addr` and the memory unchanged and leave `pop_data` unchanged. `clash_err` is 1 in the following cycle only; it is 0 after any cycle without such a clash.
- R9: In a cycle with no pull taking effect, `pop_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Push request |
| pull_req | input | 1 | Pull request |
| rsp_cmd | input | 1 | Reload pointer to top of page |
| push_data | input | 8 | Byte to push |
| sp_addr | output | 16 | Current stack address (next free location) |
| pop_data | output | 8 | Last pulled byte, registered |
| clash_err | output | 1 | One-cycle pulse after a push/pull clash |

## Verification
A corrupted offset register shows up on `sp_addr` in the very next cycle. Any lost or extra step is caught at once by comparing every cycle against an arithmetic model of the pointer. A wrong write address or wrong write ordering only becomes visible when the entry is pulled back. For that reason the sweep fills the whole page and pulls it all back, and it crosses both wrap points. A clash that leaks a write or a pointer step is exposed by the next pull or by the pointer value one cycle later.

// File: rtl/stkp_pkg.sv
// Shared definitions for the fixed-page stack pointer.
// Assumes one resolved operation per clock cycle.
package stkp_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PUSH   = 3'd1,
        OP_PULL   = 3'd2,
        OP_RELOAD = 3'd3,
        OP_CLASH  = 3'd4
    } stk_op_e;
endpackage

// File: rtl/sp_ctrl.sv
// Request arbiter: turns the raw request lines into one operation.
// The reload command wins over everything else. Push plus pull together
// is a clash, and the clash is reported as a registered one-cycle pulse.
// Assumes synchronous active-low reset.
module sp_ctrl
    import stkp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_req,
    input  logic    pull_req,
    input  logic    rsp_cmd,
    output stk_op_e op,
    output logic    clash_err
);
    // Resolve priority among the request lines.
    always_comb begin
        if (rsp_cmd)                    op = OP_RELOAD;
        else if (push_req && pull_req)  op = OP_CLASH;
        else if (push_req)              op = OP_PUSH;
        else if (pull_req)              op = OP_PULL;
        else                            op = OP_IDLE;
    end

    // Register the clash indication as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) clash_err <= 1'b0;
        else        clash_err <= (op == OP_CLASH);
    end
endmodule

// File: rtl/sp_reg.sv
// Pointer offset register: holds the writable low bits of the stack pointer.
// A push uses the current offset and then decrements it. A pull increments
// first, and the incremented offset is the read index. Arithmetic is modulo
// the page size, so both page ends wrap silently.
// Assumes synchronous active-low reset; the reset value is all ones.
module sp_reg
    import stkp_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    output logic [OFS_W-1:0] ofs_cur,
    output logic [OFS_W-1:0] ofs_up
);
    localparam logic [OFS_W-1:0] OFS_TOP = {OFS_W{1'b1}};
    localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] ofs_dn;

    // Neighbouring offsets, wrapping inside the page.
    always_comb begin
        ofs_up = ofs_q + OFS_ONE;
        ofs_dn = ofs_q - OFS_ONE;
    end

    // Update the offset according to the resolved operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= OFS_TOP;
        end else begin
            case (op)
                OP_RELOAD: ofs_q <= OFS_TOP;
                OP_PUSH:   ofs_q <= ofs_dn;
                OP_PULL:   ofs_q <= ofs_up;
                default:   ofs_q <= ofs_q;
            endcase
        end
    end

    assign ofs_cur = ofs_q;
endmodule

// File: rtl/sp_ram.sv
// Stack storage: single write port, synchronous read into an output register.
// The storage array has no reset; only the read register is reset.
// Assumes write and read are never requested in the same cycle.
module sp_ram #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a pushed byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Capture a pulled byte; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/stack_window_sp.sv
// Fixed-page stack pointer with its stack memory.
// The upper address bits come from PAGE_TOP and cannot change. Only the low
// OFS_W bits move. PAGE_TOP must have its low OFS_W bits all set, so that a
// reset or reload lands on PAGE_TOP itself.
// Assumes synchronous active-low reset.
module stack_window_sp
    import stkp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter int              OFS_W    = 6,
    parameter logic [ADDR_W-1:0] PAGE_TOP = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pull_req,
    input  logic              rsp_cmd,
    input  logic [DATA_W-1:0] push_data,
    output logic [ADDR_W-1:0] sp_addr,
    output logic [DATA_W-1:0] pop_data,
    output logic              clash_err
);
    localparam int FIX_W = ADDR_W - OFS_W;
    localparam logic [FIX_W-1:0] FIXED_HI = PAGE_TOP[ADDR_W-1:OFS_W];

    stk_op_e          op;
    logic [OFS_W-1:0] ofs_cur;
    logic [OFS_W-1:0] ofs_up;

    sp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pull_req  (pull_req),
        .rsp_cmd   (rsp_cmd),
        .op        (op),
        .clash_err (clash_err)
    );

    sp_reg #(.OFS_W(OFS_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ofs_cur (ofs_cur),
        .ofs_up  (ofs_up)
    );

    sp_ram #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op == OP_PUSH),
        .wr_idx  (ofs_cur),
        .wr_data (push_data),
        .rd_en   (op == OP_PULL),
        .rd_idx  (ofs_up),
        .rd_data (pop_data)
    );

    // Form the full address from the hardwired bits and the live offset.
    always_comb sp_addr = {FIXED_HI, ofs_cur};
endmodule

// File: rtl/sp_checker.sv
// Temporal checks on the stack pointer's ports, attached through bind.
module sp_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              pull_req,
    input logic              rsp_cmd,
    input logic [ADDR_W-1:0] sp_addr,
    input logic [DATA_W-1:0] pop_data,
    input logic              clash_err
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    logic solo_push, solo_pull, clash;
    assign solo_push = push_req && !pull_req && !rsp_cmd;
    assign solo_pull = pull_req && !push_req && !rsp_cmd;
    assign clash     = push_req && pull_req && !rsp_cmd;

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        solo_push |=> sp_addr[OFS_W-1:0] == $past(sp_addr[OFS_W-1:0]) - ONE);

    assert_pull_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        solo_pull |=> sp_addr[OFS_W-1:0] == $past(sp_addr[OFS_W-1:0]) + ONE);

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cmd |=> (sp_addr[OFS_W-1:0] == {OFS_W{1'b1}}) && !clash_err);

    assert_clash_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> clash_err && $stable(sp_addr) && $stable(pop_data));

    assert_clash_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clash |=> !clash_err);

    assert_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_pull |=> $stable(pop_data));
endmodule

bind stack_window_sp sp_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pull_req  (pull_req),
    .rsp_cmd   (rsp_cmd),
    .sp_addr   (sp_addr),
    .pop_data  (pop_data),
    .clash_err (clash_err)
);

// File: tb/stack_window_sp_tb.sv
module stack_window_sp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic        pull_req = 1'b0;
    logic        rsp_cmd = 1'b0;
    logic [7:0]  push_data = 8'h00;
    logic [15:0] sp_addr;
    logic [7:0]  pop_data;
    logic        clash_err;

    int checks = 0;
    int errors = 0;

    // Expected state
    int         m_ofs = 63;
    logic [7:0] m_mem [64];
    logic [7:0] m_pop = 8'h00;
    logic       m_err = 1'b0;

    always #2 clk = ~clk;

    stack_window_sp u_dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pull_req(pull_req),
        .rsp_cmd(rsp_cmd), .push_data(push_data), .sp_addr(sp_addr),
        .pop_data(pop_data), .clash_err(clash_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, 32'(sp_addr), 32'(16'h00C0 + m_ofs));
        chk("R5", 32'(sp_addr[15:6]), 32'h3);
        chk(req, 32'(pop_data), 32'(m_pop));
        chk(req, 32'(clash_err), 32'(m_err));
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge.
    task automatic step(input logic pu, input logic pl, input logic rs,
                        input logic [7:0] d, input string req);
        push_req = pu; pull_req = pl; rsp_cmd = rs; push_data = d;
        m_err = 1'b0;
        if (rs) m_ofs = 63;
        else if (pu && pl) m_err = 1'b1;
        else if (pu) begin m_mem[m_ofs] = d; m_ofs = (m_ofs + 63) % 64; end
        else if (pl) begin m_ofs = (m_ofs + 1) % 64; m_pop = m_mem[m_ofs]; end
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // Fill the whole page; the last push sits at 0x00C0 and wraps (R6).
        for (int i = 0; i < 64; i++)
            step(1'b1, 1'b0, 1'b0, 8'(i * 37 + 5), (i == 63) ? "R6" : "R2");
        // Push at 0x00FF again after wrapping: overwrites entry 63.
        step(1'b1, 1'b0, 1'b0, 8'hA5, "R2");

        // Pull everything back, crossing the top of the page (R7).
        for (int i = 0; i < 66; i++)
            step(1'b0, 1'b1, 1'b0, 8'h00, (m_ofs == 63) ? "R7" : "R3");

        // Idle cycles keep pop_data.
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 8'h11, "R9");

        // Clash: nothing written, nothing moved, one pulse.
        step(1'b1, 1'b1, 1'b0, 8'hEE, "R8");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R8");
        step(1'b0, 1'b1, 1'b0, 8'h00, "R8");
        step(1'b1, 1'b1, 1'b0, 8'h77, "R8");
        step(1'b1, 1'b1, 1'b0, 8'h78, "R8");
        step(1'b0, 1'b1, 1'b0, 8'h00, "R8");

        // Reload wins over push and pull.
        step(1'b1, 1'b0, 1'b1, 8'h99, "R4");
        step(1'b0, 1'b1, 1'b0, 8'h00, "R4");
        step(1'b1, 1'b1, 1'b1, 8'h98, "R4");
        step(1'b0, 1'b0, 1'b1, 8'h00, "R4");

        // Pseudo-random mix of all request combinations.
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1], (lfsr[5:2] == 4'hF), lfsr[15:8], "R3");
        end

        // Reset mid-run returns to the reset state.
        rst_n = 1'b0;
        push_req = 1'b0; pull_req = 1'b0; rsp_cmd = 1'b0;
        @(negedge clk);
        m_ofs = 63; m_pop = 8'h00; m_err = 1'b0;
        check_all("R1");
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule